// File: doc/BRIEF.md
# PCI Configuration Space Write Engine

This block holds the 256-byte configuration space of a single PCI function. It turns write requests into stored bytes according to the rules of the configuration header. A request carries a byte address, 32 bits of data and a length of 1, 2 or 4 bytes. It enters through a valid/ready stream port. A separate read port returns any aligned dword at once.

There are two ways a request is applied. An aligned 4-byte write that lands on a base-address slot or on the expansion ROM slot, where that region has a nonzero size, is stored in one cycle. The region-size mask and the fixed type bits are applied to it. Every other request is walked one byte per cycle. Each byte passes through a rule that depends on the header-type byte. That rule decides whether the byte is read-only, clears reserved command bits, freezes the low status byte, or applies write-one-to-clear to the high status byte.

Back-pressure is simple. `wr_ready` drops for exactly N cycles after a byte-path request of length N is accepted. It stays high after a region write, so region writes may issue back to back. A request must be held stable while `wr_valid` is high and `wr_ready` is low. `remap_pulse` tells the address decoder elsewhere that its mappings must be rebuilt.

Top module: `pcfg_space_wr`

## Requirements
- R1: After reset, `rd_data` for dword index k returns bytes 4k..4k+3, little-endian (byte 4k in bits 7:0). The reset contents are as follows:
  - bytes 0x00-0x03 come from `ID_WORD`;
  - bytes 0x08-0x0B come from `CLASS_WORD`;
  - byte 0x0E comes from `HDR_TYPE`;
  - byte 0x3D comes from `IRQ_PIN`;
  - bytes 0x2C-0x2F come from `SUBSYS_WORD`;
  - bytes 0x06-0x07 come from `STATUS_INIT`;
  - every other byte is zero.
- R2: A request is taken on a clock edge where `wr_valid` and `wr_ready` are both high. After a byte-path request of length N, `wr_ready` is low for exactly N cycles. After a region-path request it stays high.
- R3: The byte path writes byte k of `wr_data` (bits 8k+7:8k) to address (`wr_addr`+k) mod 256, for k from 0 to N-1.
- R4: When byte 0x0E is 0x00 or 0x80, the endpoint map applies. These bytes are then read-only: 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x2C-0x34 and 0x3D.
- R5: Any other value of byte 0x0E (0x01 included) selects the bridge map. These bytes are then read-only: 0x00-0x03, 0x08-0x0B, 0x0E, 0x38-0x3B and 0x3D.
- R6: Byte 0x05 always stores bits 7:3 as zero and takes bits 2:0 from the written data.
- R7: Byte 0x06 is never changed by a write.
- R8: Byte 0x07 is write-one-to-clear: a 1 written to bit n clears bit n. Bits 1 and 2 of that byte never clear.
- R9: A 4-byte request at an aligned address in 0x10-0x24 addresses slot s = (addr-0x10)/4. If the size of slot s is nonzero, the stored dword is (data AND NOT(size-1)) OR the slot's 4-bit type.
- R10: A 4-byte request at 0x30 with a nonzero ROM size stores (data AND NOT(size-1)), with bit 0 kept from the data.
- R11: A region request whose slot size is zero takes the byte path, as does an unaligned 4-byte request in the base-address range.
- R12: `remap_pulse` is high for one cycle after a region-path write. It is also high for one cycle after the last byte of a byte-path request whose range [addr, addr+N) overlaps 0x04-0x05. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Engine can take a request |
| wr_addr | input | 8 | Byte address of the first byte |
| wr_data | input | 32 | Write data, lowest byte first |
| wr_len | input | 3 | Byte count: 1, 2 or 4 |
| rd_dword | input | 6 | Dword index for the read port |
| rd_data | output | 32 | Dword contents, little-endian |
| remap_pulse | output | 1 | Mappings must be recomputed |

## Verification
The same write stream is applied to four copies that differ only in header type: 0x00, 0x80, 0x01 and 0x42. Each write's effect can therefore be compared between the endpoint and bridge maps, and the fallback of unknown header values to the bridge map is covered. The patterns cover the following:
- single, 2-byte and 4-byte byte-path writes, including one that wraps past 0xFF;
- writes whose range ends exactly at 0x04 or starts at 0x03, which separate a command overlap from a near miss;
- all-ones and mixed values on sized slots, on the ROM slot and on a zero-size slot, which separate size masking, type insertion, enable-bit keeping and fall-through;
- all-ones writes on the status bytes, which separate the frozen low byte from the write-one-to-clear high byte.

The stall length and the remap pulse are counted for every request.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int unsigned CFG_BYTES  = 256;
  localparam int unsigned BAR_SLOTS  = 6;
  localparam int unsigned REGIONS    = BAR_SLOTS + 1;
  localparam int unsigned ROM_SLOT   = BAR_SLOTS;
  localparam int unsigned TYPE_W     = 4;

  typedef logic [7:0] cfg_addr_t;
  typedef logic [7:0] cfg_byte_t;

  localparam cfg_addr_t A_CMD_HI   = 8'h05;
  localparam cfg_addr_t A_STAT_LO  = 8'h06;
  localparam cfg_addr_t A_STAT_HI  = 8'h07;
  localparam cfg_addr_t A_HDR      = 8'h0E;
  localparam cfg_addr_t A_BAR_LO   = 8'h10;
  localparam cfg_addr_t A_BAR_END  = 8'h28;
  localparam cfg_addr_t A_ROM      = 8'h30;

  localparam cfg_byte_t CMD_HI_RSVD  = 8'hF8;
  localparam cfg_byte_t STAT_HI_KEEP = 8'h06;

  typedef enum logic {MAP_ENDPOINT, MAP_BRIDGE} hdr_map_e;

  function automatic hdr_map_e map_of(input cfg_byte_t ht);
    return (ht == 8'h00 || ht == 8'h80) ? MAP_ENDPOINT : MAP_BRIDGE;
  endfunction

  function automatic logic common_ro(input cfg_addr_t a);
    return (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || a == A_HDR || a == 8'h3D;
  endfunction

  function automatic logic endpoint_ro(input cfg_addr_t a);
    return common_ro(a) || (a >= A_BAR_LO && a < A_BAR_END) || (a >= 8'h2C && a <= 8'h34);
  endfunction

  function automatic logic bridge_ro(input cfg_addr_t a);
    return common_ro(a) || (a >= 8'h38 && a <= 8'h3B);
  endfunction

endpackage

// File: rtl/pcfg_byte_rule.sv
module pcfg_byte_rule
  import pcfg_pkg::*;
(
  input  cfg_addr_t addr,
  input  cfg_byte_t hdr_type,
  input  cfg_byte_t old_byte,
  input  cfg_byte_t new_byte,
  output cfg_byte_t next_byte
);

  logic read_only;

  always_comb begin
    if (map_of(hdr_type) == MAP_ENDPOINT) read_only = endpoint_ro(addr);
    else                                  read_only = bridge_ro(addr);
  end

  always_comb begin
    if (addr == A_CMD_HI)       next_byte = new_byte & ~CMD_HI_RSVD;
    else if (addr == A_STAT_LO) next_byte = old_byte;
    else if (addr == A_STAT_HI) next_byte = old_byte & ~(new_byte & ~STAT_HI_KEEP);
    else if (read_only)         next_byte = old_byte;
    else                        next_byte = new_byte;
  end

endmodule

// File: rtl/pcfg_region_mask.sv
module pcfg_region_mask
  import pcfg_pkg::*;
#(
  parameter logic [REGIONS-1:0][31:0]       REGION_SIZE = '0,
  parameter logic [BAR_SLOTS-1:0][TYPE_W-1:0] REGION_TYPE = '0
) (
  input  cfg_addr_t   addr,
  input  logic [2:0]  len,
  input  logic [31:0] data,
  output logic        hit,
  output logic [31:0] value
);

  localparam int unsigned SLOT_W = $clog2(REGIONS);

  logic [REGIONS-1:0][31:0] keep_mask;
  logic [REGIONS-1:0][31:0] or_bits;
  logic [REGIONS-1:0]       sized;

  for (genvar g = 0; g < REGIONS; g++) begin : g_region
    if (g == ROM_SLOT) begin : g_rom
      assign keep_mask[g] = ~(REGION_SIZE[g] - 32'd1) | 32'd1;
      assign or_bits[g]   = '0;
    end else begin : g_bar
      assign keep_mask[g] = ~(REGION_SIZE[g] - 32'd1);
      assign or_bits[g]   = {{(32-TYPE_W){1'b0}}, REGION_TYPE[g]};
    end
    assign sized[g] = (REGION_SIZE[g] != 32'd0);
  end

  logic              in_bar, in_rom;
  logic [SLOT_W-1:0] slot;
  cfg_addr_t         rel;

  always_comb begin
    in_bar = (len == 3'd4) && (addr[1:0] == 2'b00) && (addr >= A_BAR_LO) && (addr < A_BAR_END);
    in_rom = (len == 3'd4) && (addr == A_ROM);
    rel    = addr - A_BAR_LO;
    slot   = in_rom ? SLOT_W'(ROM_SLOT) : SLOT_W'(rel[7:2]);
    hit    = (in_bar || in_rom) && sized[slot];
    value  = (data & keep_mask[slot]) | or_bits[slot];
  end

endmodule

// File: rtl/pcfg_walker.sv
module pcfg_walker
  import pcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  cfg_addr_t   wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  wr_len,
  input  logic        region_hit,
  output logic        region_we,
  output logic        step_en,
  output cfg_addr_t   step_addr,
  output cfg_byte_t   step_byte,
  output logic        remap_pulse
);

  logic [2:0]  cnt_q;
  cfg_addr_t   addr_q;
  logic [31:0] data_q;
  logic        ovl_q, remap_q;
  logic        accept, overlap;

  assign wr_ready  = rst_n && (cnt_q == 3'd0);
  assign accept    = wr_valid && wr_ready;
  assign region_we = accept && region_hit;
  assign step_en   = (cnt_q != 3'd0);
  assign step_addr = addr_q;
  assign step_byte = data_q[7:0];
  assign remap_pulse = remap_q;

  always_comb begin
    overlap = (({1'b0, wr_addr} + {6'd0, wr_len}) > 9'd4) && (wr_addr < 8'd6) && (wr_len != 3'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      ovl_q   <= 1'b0;
      remap_q <= 1'b0;
    end else begin
      remap_q <= 1'b0;
      if (region_we) begin
        remap_q <= 1'b1;
      end else if (accept) begin
        cnt_q  <= wr_len;
        addr_q <= wr_addr;
        data_q <= wr_data;
        ovl_q  <= overlap;
      end else if (step_en) begin
        cnt_q  <= cnt_q - 3'd1;
        addr_q <= addr_q + 8'd1;
        data_q <= data_q >> 8;
        if (cnt_q == 3'd1) remap_q <= ovl_q;
      end
    end
  end

  // R2: region writes never stall; byte writes always stall
  p_region_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    region_we |=> wr_ready);
  p_byte_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !region_hit && wr_len != 3'd0) |=> !wr_ready);
  // R12: the remap pulse only appears once the engine is idle again
  p_remap_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |-> wr_ready);

endmodule

// File: rtl/pcfg_space_wr.sv
module pcfg_space_wr
  import pcfg_pkg::*;
#(
  parameter logic [31:0] ID_WORD     = 32'h1234_ABCD,
  parameter logic [31:0] CLASS_WORD  = 32'h0C03_0001,
  parameter logic [31:0] SUBSYS_WORD = 32'h0000_0000,
  parameter logic [15:0] STATUS_INIT = 16'hFF10,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter logic [7:0]  IRQ_PIN     = 8'h01,
  parameter logic [REGIONS-1:0][31:0] REGION_SIZE =
    {32'h0000_0800, 32'd0, 32'd0, 32'd0, 32'd0, 32'h0000_0020, 32'h0000_1000},
  parameter logic [BAR_SLOTS-1:0][TYPE_W-1:0] REGION_TYPE =
    {4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h8}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  wr_len,
  input  logic [5:0]  rd_dword,
  output logic [31:0] rd_data,
  output logic        remap_pulse
);

  function automatic cfg_byte_t reset_byte(input int unsigned a);
    cfg_byte_t v;
    v = 8'h00;
    if (a <= 3)                  v = ID_WORD[8*a +: 8];
    else if (a >= 8 && a <= 11)  v = CLASS_WORD[8*(a-8) +: 8];
    else if (a == 6 || a == 7)   v = STATUS_INIT[8*(a-6) +: 8];
    else if (a == 14)            v = HDR_TYPE;
    else if (a >= 44 && a <= 47) v = SUBSYS_WORD[8*(a-44) +: 8];
    else if (a == 61)            v = IRQ_PIN;
    return v;
  endfunction

  cfg_byte_t   cfg [CFG_BYTES];
  logic        region_hit, region_we, step_en;
  logic [31:0] region_val;
  cfg_addr_t   step_addr;
  cfg_byte_t   step_byte, rule_next;

  pcfg_region_mask #(
    .REGION_SIZE (REGION_SIZE),
    .REGION_TYPE (REGION_TYPE)
  ) u_mask (
    .addr  (wr_addr),
    .len   (wr_len),
    .data  (wr_data),
    .hit   (region_hit),
    .value (region_val)
  );

  pcfg_walker u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_len      (wr_len),
    .region_hit  (region_hit),
    .region_we   (region_we),
    .step_en     (step_en),
    .step_addr   (step_addr),
    .step_byte   (step_byte),
    .remap_pulse (remap_pulse)
  );

  pcfg_byte_rule u_rule (
    .addr      (step_addr),
    .hdr_type  (cfg[A_HDR]),
    .old_byte  (cfg[step_addr]),
    .new_byte  (step_byte),
    .next_byte (rule_next)
  );

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    localparam cfg_addr_t IA  = 8'(i);
    localparam cfg_byte_t RST = reset_byte(i);
    cfg_byte_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      q <= RST;
      else if (region_we && wr_addr[7:2] == IA[7:2])   q <= region_val[8*IA[1:0] +: 8];
      else if (step_en && step_addr == IA)             q <= rule_next;
    end
    assign cfg[i] = q;
  end

  assign rd_data = {cfg[{rd_dword, 2'd3}], cfg[{rd_dword, 2'd2}],
                    cfg[{rd_dword, 2'd1}], cfg[{rd_dword, 2'd0}]};

  // R6: reserved command bits never hold a one
  p_cmd_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[A_CMD_HI] & CMD_HI_RSVD) == 8'h00);
  // R7: low status byte is frozen
  p_stat_lo_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg[A_STAT_LO]));
  // R8: protected high-status bits never fall
  p_stat_hi_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cfg[A_STAT_HI][1]) && !$fell(cfg[A_STAT_HI][2]));
  // R4/R5: identification and header-type bytes are read-only in both maps
  p_id_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg[0]) && $stable(cfg[8]) && $stable(cfg[A_HDR]));

endmodule

// File: tb/pcfg_space_wr_test.sv
module pcfg_space_wr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wr_len = '0;
  logic [5:0]  rd_dword = '0;
  logic        rdy [4];
  logic        rmp [4];
  logic [31:0] rdd [4];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pcfg_space_wr #(.HDR_TYPE(8'h00)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(rdy[0]), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_len(wr_len), .rd_dword(rd_dword), .rd_data(rdd[0]), .remap_pulse(rmp[0]));
  pcfg_space_wr #(.HDR_TYPE(8'h80)) uut_mf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(rdy[1]), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_len(wr_len), .rd_dword(rd_dword), .rd_data(rdd[1]), .remap_pulse(rmp[1]));
  pcfg_space_wr #(.HDR_TYPE(8'h01)) uut_br (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(rdy[2]), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_len(wr_len), .rd_dword(rd_dword), .rd_data(rdd[2]), .remap_pulse(rmp[2]));
  pcfg_space_wr #(.HDR_TYPE(8'h42)) uut_ox (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(rdy[3]), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_len(wr_len), .rd_dword(rd_dword), .rd_data(rdd[3]), .remap_pulse(rmp[3]));

  function automatic logic [7:0] hdr_of(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h80;
      2: return 8'h01;
      default: return 8'h42;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // read one dword from all copies; copies 0,1 use the endpoint map, 2,3 the bridge map
  task automatic chk_rd(input string tag, input logic [7:0] addr,
                        input logic [31:0] exp_ep, input logic [31:0] exp_br);
    @(negedge clk);
    rd_dword = addr[7:2];
    #1;
    for (int k = 0; k < 4; k++) chk($sformatf("%s copy%0d @%h", tag, k, addr), rdd[k], (k < 2) ? exp_ep : exp_br);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] n,
                    output int low, output int pulses);
    @(negedge clk);
    while (!rdy[0]) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_len = n;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    low = 0; pulses = 0;
    forever begin
      if (rmp[0]) pulses++;
      if (rdy[0]) break;
      low++;
      @(negedge clk);
    end
    @(negedge clk);
    if (rmp[0]) pulses++;
  endtask

  task automatic wr_chk(input string tag, input logic [7:0] a, input logic [31:0] d,
                        input logic [2:0] n, input int exp_low, input int exp_pulses);
    int low, pulses;
    wr(a, d, n, low, pulses);
    chk({tag, " R2 stall cycles"}, low, exp_low);
    chk({tag, " R12 remap pulses"}, pulses, exp_pulses);
  endtask

  task automatic t_reset;
    chk_rd("R1 id", 8'h00, 32'h1234_ABCD, 32'h1234_ABCD);
    chk_rd("R1 cmd/status", 8'h04, 32'hFF10_0000, 32'hFF10_0000);
    chk_rd("R1 class", 8'h08, 32'h0C03_0001, 32'h0C03_0001);
    chk_rd("R1 irq pin", 8'h3C, 32'h0000_0100, 32'h0000_0100);
    @(negedge clk); rd_dword = 6'd3; #1;
    for (int k = 0; k < 4; k++) chk($sformatf("R1 header copy%0d", k), rdd[k], {8'h00, hdr_of(k), 16'h0});
    chk("R1 ready after reset", rdy[0], 1'b1);
    chk("R12 remap low after reset", rmp[0], 1'b0);
  endtask

  task automatic t_plain;
    wr_chk("R3 single", 8'h3C, 32'h0000_00AA, 3'd1, 1, 0);
    chk_rd("R3 single", 8'h3C, 32'h0000_01AA, 32'h0000_01AA);
    wr_chk("R3 quad", 8'h3C, 32'h5566_7788, 3'd4, 4, 0);
    chk_rd("R3 quad keeps 0x3D", 8'h3C, 32'h5566_0188, 32'h5566_0188);
  endtask

  task automatic t_command;
    wr_chk("R6 cmd", 8'h04, 32'h0000_FFFF, 3'd2, 2, 1);
    chk_rd("R6 reserved cleared", 8'h04, 32'hFF10_07FF, 32'hFF10_07FF);
    wr_chk("R12 start 0x03", 8'h03, 32'h0000_4200, 3'd2, 2, 1);
    chk_rd("R3 cmd low byte", 8'h04, 32'hFF10_0742, 32'hFF10_0742);
    wr_chk("R12 end at 0x04", 8'h00, 32'h0000_0000, 3'd4, 4, 0);
    chk_rd("R4 id untouched", 8'h00, 32'h1234_ABCD, 32'h1234_ABCD);
  endtask

  task automatic t_status;
    wr_chk("R8 status", 8'h06, 32'h0000_FFFF, 3'd2, 2, 0);
    chk_rd("R7 R8 status", 8'h04, 32'h0610_0742, 32'h0610_0742);
    wr_chk("R8 protected", 8'h07, 32'h0000_0006, 3'd1, 1, 0);
    chk_rd("R8 protected bits", 8'h04, 32'h0610_0742, 32'h0610_0742);
  endtask

  task automatic t_maps;
    wr_chk("R5 0x38", 8'h38, 32'h1122_3344, 3'd4, 4, 0);
    chk_rd("R4 R5 0x38", 8'h38, 32'h1122_3344, 32'h0000_0000);
    wr_chk("R4 cap", 8'h34, 32'h0000_0040, 3'd1, 1, 0);
    chk_rd("R4 R5 cap", 8'h34, 32'h0000_0000, 32'h0000_0040);
    wr_chk("R4 subsys", 8'h2C, 32'hCAFE_F00D, 3'd4, 4, 0);
    chk_rd("R4 R5 subsys", 8'h2C, 32'h0000_0000, 32'hCAFE_F00D);
    wr_chk("R4 class", 8'h08, 32'h0000_0000, 3'd4, 4, 0);
    chk_rd("R5 class ro", 8'h08, 32'h0C03_0001, 32'h0C03_0001);
    wr_chk("R5 hdr", 8'h0E, 32'h0000_0001, 3'd1, 1, 0);
    @(negedge clk); rd_dword = 6'd3; #1;
    for (int k = 0; k < 4; k++) chk($sformatf("R5 header ro copy%0d", k), rdd[k], {8'h00, hdr_of(k), 16'h0});
  endtask

  task automatic t_bar;
    wr_chk("R9 bar0", 8'h10, 32'hFFFF_FFFF, 3'd4, 0, 1);
    chk_rd("R9 bar0 mask+type", 8'h10, 32'hFFFF_F008, 32'hFFFF_F008);
    wr_chk("R9 bar1", 8'h14, 32'hFFFF_FFFF, 3'd4, 0, 1);
    chk_rd("R9 bar1 io type", 8'h14, 32'hFFFF_FFE1, 32'hFFFF_FFE1);
    wr_chk("R9 bar0 mixed", 8'h10, 32'h1234_5678, 3'd4, 0, 1);
    chk_rd("R9 bar0 mixed", 8'h10, 32'h1234_5008, 32'h1234_5008);
  endtask

  task automatic t_rom;
    wr_chk("R10 rom ones", 8'h30, 32'hFFFF_FFFF, 3'd4, 0, 1);
    chk_rd("R10 rom enable kept", 8'h30, 32'hFFFF_F801, 32'hFFFF_F801);
    wr_chk("R10 rom mixed", 8'h30, 32'h1234_5670, 3'd4, 0, 1);
    chk_rd("R10 rom mixed", 8'h30, 32'h1234_5000, 32'h1234_5000);
  endtask

  task automatic t_fallthrough;
    wr_chk("R11 zero size", 8'h18, 32'hDEAD_BEEF, 3'd4, 4, 0);
    chk_rd("R11 zero size", 8'h18, 32'h0000_0000, 32'hDEAD_BEEF);
    wr_chk("R11 unaligned", 8'h15, 32'h4433_2211, 3'd4, 4, 0);
    chk_rd("R11 unaligned bar1", 8'h14, 32'hFFFF_FFE1, 32'h3322_11E1);
    chk_rd("R11 unaligned bar2", 8'h18, 32'h0000_0000, 32'hDEAD_BE44);
  endtask

  task automatic t_wrap;
    wr_chk("R3 wrap", 8'hFF, 32'h0000_BBAA, 3'd2, 2, 0);
    chk_rd("R3 wrap top", 8'hFC, 32'hAA00_0000, 32'hAA00_0000);
    chk_rd("R3 wrap id", 8'h00, 32'h1234_ABCD, 32'h1234_ABCD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_command();
    t_status();
    t_maps();
    t_bar();
    t_rom();
    t_fallthrough();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule